// File: doc/BRIEF.md
# Receive Ring Page Manager

This block places incoming frames into a circular receive area of local packet memory. The memory is divided into 256-byte pages, and the ring occupies the pages from a start page up to, but not including, a stop page. Every frame is stored from the beginning of the current page. The first four bytes of that page are kept free for a header. The data bytes follow from offset 4 and run on through as many pages as they need, wrapping from the last ring page back to the start page.

When the frame ends, the block completes the header. The header holds the receive status, the page where the next frame will start, and a 16-bit byte count. Only after the last header byte is written does the current page move forward. Software consumes frames by reading from the page after the boundary and then moving the boundary forward. The block never writes into the boundary page. If a frame would reach that page, the block raises a one-cycle overwrite warning and drops the frame. It then drops every later frame, reporting each one as missed, until software rewrites the boundary.

Top module: `rx_ring_pgmgr`

## Requirements
- R1: After reset the current page is START+1, the boundary is START, the ring reads as empty and no memory write is issued.
- R2: A write with reg_we sets one register chosen by reg_sel: 0 ring start, 1 ring stop (exclusive), 2 boundary, 3 current page. ring_empty is 1 exactly when the page after the boundary equals the current page, where the page after stop-1 is the start page.
- R3: Data byte k (counting from 0) of a frame is written to offset 4+k of the current page, continuing across pages. The write appears on the memory port in the cycle after the byte strobe.
- R4: When data passes offset 255 of page stop-1, the next byte goes to offset 0 of the start page.
- R5: The header sits at offsets 0..3 of the frame's first page. Offset 0 holds the status byte, offset 1 the next-frame page, offset 2 the low byte of the count and offset 3 the high byte. The count is the number of data bytes plus 4. The four header bytes appear on the memory port in the four cycles that follow the end-of-frame strobe, in offset order.
- R6: The next-frame page is the page after the one holding the last data byte, with wrap. If the frame ends exactly at a page end, it is the following page. The current page takes this value in the same cycle as the last header byte, not earlier.
- R7: A frame whose status bit 0 is clear is discarded: no header is written, and the current page is unchanged, so the next frame reuses the same page. When keep_bad is 1 such a frame is stored like any other.
- R8: If a data byte would cross into the boundary page, or if the next-frame page computed at end of frame equals the boundary, ovw_evt pulses for one cycle. No further byte of that frame is written, no header is written, the current page is unchanged, and frame_missed pulses at that frame's end.
- R9: After an overwrite warning, every later frame is dropped with no memory write and a frame_missed pulse at its end. This continues until software writes the boundary register.
- R10: An end-of-frame strobe with no data bytes stores a header only: count 4, next page equal to the page after the current page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 start, 1 stop, 2 boundary, 3 current) |
| reg_wdata | input | PW | Page value to write |
| keep_bad | input | 1 | Store frames with bad status |
| rx_vld | input | 1 | Frame data byte strobe |
| rx_data | input | 8 | Frame data byte |
| rx_eof | input | 1 | End-of-frame strobe (carries no byte) |
| rx_status | input | 8 | Receive status, valid with rx_eof; bit 0 means intact |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | PW+8 | Packet memory byte address {page, offset} |
| mem_wdata | output | 8 | Packet memory write data |
| ovw_evt | output | 1 | One-cycle overwrite warning |
| frame_missed | output | 1 | One-cycle pulse per dropped frame |
| ring_empty | output | 1 | Page after boundary equals current page |
| cur_page | output | PW | Current page register |
| bnd_page | output | PW | Boundary register |

## Verification
A data byte shows on the memory port one cycle after its strobe. The four header bytes appear one cycle apart, starting one cycle after the end-of-frame strobe. The current page moves together with the fourth header byte. Register writes, ring_empty and the event pulses all settle one cycle after their cause. The bench drives every input on the falling edge and samples on the next falling edge. This way each due cycle is read exactly: the header-timing test checks the port cycle by cycle, and the other tests read memory and counters logged from the port only after the frame has fully settled.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int OFS_W       = 8;
  localparam int HDR_BYTES   = 4;
  localparam int CNT_W       = 16;
  localparam int ST_GOOD_BIT = 0;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_STOP  = 2'd1,
    SEL_BND   = 2'd2,
    SEL_CURR  = 2'd3
  } rxr_sel_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_DROP,
    S_H1,
    S_H2,
    S_H3
  } rxr_state_e;

endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] pg,
  input  logic [PW-1:0] start_pg,
  input  logic [PW-1:0] stop_pg,
  output logic [PW-1:0] nxt_pg
);

  logic [PW-1:0] inc_pg;

  always_comb begin
    inc_pg = pg + 1'b1;
    nxt_pg = (inc_pg == stop_pg) ? start_pg : inc_pg;
  end

endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int PW    = 8,
  parameter int START = 8'h46,
  parameter int STOP  = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [PW-1:0] reg_wdata,
  input  logic          adv_en,
  input  logic [PW-1:0] adv_pg,
  output logic [PW-1:0] start_pg,
  output logic [PW-1:0] stop_pg,
  output logic [PW-1:0] bnd_pg,
  output logic [PW-1:0] cur_pg,
  output logic          bnd_wr
);

  localparam logic [PW-1:0] START_P = START[PW-1:0];
  localparam logic [PW-1:0] STOP_P  = STOP[PW-1:0];
  localparam logic [PW-1:0] CUR_RST = START_P + 1'b1;

  logic [PW-1:0] start_q, start_d;
  logic [PW-1:0] stop_q,  stop_d;
  logic [PW-1:0] bnd_q,   bnd_d;
  logic [PW-1:0] cur_q,   cur_d;
  logic          upd_en;

  always_comb begin
    start_d = start_q;
    stop_d  = stop_q;
    bnd_d   = bnd_q;
    cur_d   = cur_q;
    if (reg_we) begin
      unique case (rxr_sel_e'(reg_sel))
        SEL_START: start_d = reg_wdata;
        SEL_STOP:  stop_d  = reg_wdata;
        SEL_BND:   bnd_d   = reg_wdata;
        SEL_CURR:  cur_d   = reg_wdata;
        default:   ;
      endcase
    end
    if (adv_en) begin
      cur_d = adv_pg;
    end
    upd_en = reg_we | adv_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= START_P;
      stop_q  <= STOP_P;
      bnd_q   <= START_P;
      cur_q   <= CUR_RST;
    end else if (upd_en) begin
      start_q <= start_d;
      stop_q  <= stop_d;
      bnd_q   <= bnd_d;
      cur_q   <= cur_d;
    end
  end

  assign start_pg = start_q;
  assign stop_pg  = stop_q;
  assign bnd_pg   = bnd_q;
  assign cur_pg   = cur_q;
  assign bnd_wr   = reg_we && (reg_sel == 2'(SEL_BND));

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            keep_bad,
  input  logic            rx_vld,
  input  logic [7:0]      rx_data,
  input  logic            rx_eof,
  input  logic [7:0]      rx_status,
  input  logic [PW-1:0]   start_pg,
  input  logic [PW-1:0]   stop_pg,
  input  logic [PW-1:0]   bnd_pg,
  input  logic [PW-1:0]   cur_pg,
  input  logic            bnd_wr,
  output logic            adv_en,
  output logic [PW-1:0]   adv_pg,
  output logic            mem_we,
  output logic [PW+OFS_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            ovw_evt,
  output logic            frame_missed
);

  localparam int AW = PW + OFS_W;
  localparam logic [OFS_W-1:0] OFS_DATA = OFS_W'(HDR_BYTES);
  localparam logic [OFS_W-1:0] OFS_LAST = {OFS_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BYTES);

  rxr_state_e       state_q, state_d;
  logic [PW-1:0]    wpage_q, wpage_d;
  logic [OFS_W-1:0] wofs_q,  wofs_d;
  logic [CNT_W-1:0] bcnt_q,  bcnt_d;
  logic [PW-1:0]    next_q,  next_d;
  logic             ovf_q,   ovf_d;
  logic             mwe_q,   mwe_d;
  logic [AW-1:0]    maddr_q, maddr_d;
  logic [7:0]       mdat_q,  mdat_d;
  logic             ovw_q,   ovw_d;
  logic             miss_q,  miss_d;

  logic [PW-1:0]    step_in, step_out, eof_next;
  logic             frame_good;
  logic             dp_en;

  // One page stepper serves both the byte path and the end-of-frame path
  assign step_in = (state_q == S_IDLE) ? cur_pg : wpage_q;

  rxr_page_step #(.PW(PW)) u_step (
    .pg       (step_in),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .nxt_pg   (step_out)
  );

  always_comb begin
    frame_good = rx_status[ST_GOOD_BIT] | keep_bad;
    if (state_q == S_IDLE) begin
      eof_next = step_out;
    end else begin
      eof_next = (wofs_q == '0) ? wpage_q : step_out;
    end
  end

  always_comb begin
    state_d = state_q;
    wpage_d = wpage_q;
    wofs_d  = wofs_q;
    bcnt_d  = bcnt_q;
    next_d  = next_q;
    ovf_d   = bnd_wr ? 1'b0 : ovf_q;
    mwe_d   = 1'b0;
    maddr_d = maddr_q;
    mdat_d  = mdat_q;
    ovw_d   = 1'b0;
    miss_d  = 1'b0;

    unique case (state_q)
      S_IDLE, S_RECV: begin
        if (rx_eof) begin
          state_d = S_IDLE;
          if (state_q == S_IDLE) begin
            bcnt_d = CNT_HDR;
          end
          if (ovf_q && state_q == S_IDLE) begin
            miss_d = 1'b1;
          end else if (!frame_good) begin
            state_d = S_IDLE;
          end else if (eof_next == bnd_pg) begin
            ovw_d  = 1'b1;
            ovf_d  = 1'b1;
            miss_d = 1'b1;
          end else begin
            mwe_d   = 1'b1;
            maddr_d = {cur_pg, OFS_W'(0)};
            mdat_d  = rx_status;
            next_d  = eof_next;
            state_d = S_H1;
          end
        end else if (rx_vld) begin
          if (state_q == S_IDLE) begin
            if (ovf_q) begin
              state_d = S_DROP;
            end else begin
              mwe_d   = 1'b1;
              maddr_d = {cur_pg, OFS_DATA};
              mdat_d  = rx_data;
              wpage_d = cur_pg;
              wofs_d  = OFS_DATA + 1'b1;
              bcnt_d  = CNT_HDR + 1'b1;
              state_d = S_RECV;
            end
          end else begin
            mwe_d   = 1'b1;
            maddr_d = {wpage_q, wofs_q};
            mdat_d  = rx_data;
            bcnt_d  = bcnt_q + 1'b1;
            wofs_d  = wofs_q + 1'b1;
            if (wofs_q == OFS_LAST) begin
              if (step_out == bnd_pg) begin
                ovw_d   = 1'b1;
                ovf_d   = 1'b1;
                state_d = S_DROP;
              end else begin
                wpage_d = step_out;
              end
            end
          end
        end
      end
      S_DROP: begin
        if (rx_eof) begin
          miss_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_H1: begin
        mwe_d   = 1'b1;
        maddr_d = {cur_pg, OFS_W'(1)};
        mdat_d  = 8'(next_q);
        state_d = S_H2;
      end
      S_H2: begin
        mwe_d   = 1'b1;
        maddr_d = {cur_pg, OFS_W'(2)};
        mdat_d  = bcnt_q[7:0];
        state_d = S_H3;
      end
      S_H3: begin
        mwe_d   = 1'b1;
        maddr_d = {cur_pg, OFS_W'(3)};
        mdat_d  = bcnt_q[15:8];
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase

    dp_en = mwe_d | (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ovf_q   <= 1'b0;
      mwe_q   <= 1'b0;
      ovw_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
      mwe_q   <= mwe_d;
      ovw_q   <= ovw_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpage_q <= '0;
      wofs_q  <= '0;
      bcnt_q  <= '0;
      next_q  <= '0;
      maddr_q <= '0;
      mdat_q  <= '0;
    end else if (dp_en) begin
      wpage_q <= wpage_d;
      wofs_q  <= wofs_d;
      bcnt_q  <= bcnt_d;
      next_q  <= next_d;
      maddr_q <= maddr_d;
      mdat_q  <= mdat_d;
    end
  end

  assign adv_en       = (state_q == S_H3);
  assign adv_pg       = next_q;
  assign mem_we       = mwe_q;
  assign mem_addr     = maddr_q;
  assign mem_wdata    = mdat_q;
  assign ovw_evt      = ovw_q;
  assign frame_missed = miss_q;

endmodule

// File: rtl/rx_ring_pgmgr.sv
module rx_ring_pgmgr
  import rxr_pkg::*;
#(
  parameter int PW    = 8,
  parameter int START = 8'h46,
  parameter int STOP  = 8'h80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [PW-1:0]   reg_wdata,
  input  logic            keep_bad,
  input  logic            rx_vld,
  input  logic [7:0]      rx_data,
  input  logic            rx_eof,
  input  logic [7:0]      rx_status,
  output logic            mem_we,
  output logic [PW+7:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            ovw_evt,
  output logic            frame_missed,
  output logic            ring_empty,
  output logic [PW-1:0]   cur_page,
  output logic [PW-1:0]   bnd_page
);

  logic [PW-1:0] start_pg, stop_pg, bnd_pg, cur_pg, adv_pg, bnd_after;
  logic          adv_en, bnd_wr;

  rxr_regs #(.PW(PW), .START(START), .STOP(STOP)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .adv_en    (adv_en),
    .adv_pg    (adv_pg),
    .start_pg  (start_pg),
    .stop_pg   (stop_pg),
    .bnd_pg    (bnd_pg),
    .cur_pg    (cur_pg),
    .bnd_wr    (bnd_wr)
  );

  rxr_ctrl #(.PW(PW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .keep_bad     (keep_bad),
    .rx_vld       (rx_vld),
    .rx_data      (rx_data),
    .rx_eof       (rx_eof),
    .rx_status    (rx_status),
    .start_pg     (start_pg),
    .stop_pg      (stop_pg),
    .bnd_pg       (bnd_pg),
    .cur_pg       (cur_pg),
    .bnd_wr       (bnd_wr),
    .adv_en       (adv_en),
    .adv_pg       (adv_pg),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .ovw_evt      (ovw_evt),
    .frame_missed (frame_missed)
  );

  rxr_page_step #(.PW(PW)) u_bnd_step (
    .pg       (bnd_pg),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .nxt_pg   (bnd_after)
  );

  assign ring_empty = (bnd_after == cur_pg);
  assign cur_page   = cur_pg;
  assign bnd_page   = bnd_pg;

endmodule

// File: rtl/rxr_pgmgr_chk.sv
module rxr_pgmgr_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          mem_we,
  input logic [PW+7:0] mem_addr,
  input logic          ovw_evt,
  input logic          frame_missed,
  input logic [PW-1:0] cur_page,
  input logic [PW-1:0] start_pg,
  input logic [PW-1:0] stop_pg
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4: every memory write stays inside the ring
  a_r4_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[PW+7:8] >= start_pg) && (mem_addr[PW+7:8] < stop_pg));

  // R6: the current page only moves by itself together with the last header byte
  a_r6_adv_with_hdr_end: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (cur_page != $past(cur_page)) && !$past(reg_we)
      |-> mem_we && (mem_addr[7:0] == 8'd3));

  // R8: the warning is a single pulse and stops all writes in the next cycle
  a_r8_ovw_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ovw_evt |=> !mem_we && !ovw_evt);

  // R9: a missed frame never coincides with a memory write
  a_r9_missed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    frame_missed |-> !mem_we);

endmodule

bind rx_ring_pgmgr rxr_pgmgr_chk #(.PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .ovw_evt      (ovw_evt),
  .frame_missed (frame_missed),
  .cur_page     (cur_page),
  .start_pg     (start_pg),
  .stop_pg      (stop_pg)
);

// File: tb/tb_rx_ring_pgmgr.sv
module tb_rx_ring_pgmgr;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;

  logic          clk, rst_n;
  logic          reg_we;
  logic [1:0]    reg_sel;
  logic [PW-1:0] reg_wdata;
  logic          keep_bad, rx_vld, rx_eof;
  logic [7:0]    rx_data, rx_status;
  logic          mem_we, ovw_evt, frame_missed, ring_empty;
  logic [PW+7:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [PW-1:0] cur_page, bnd_page;

  int n_cmp, n_bad;
  int n_wr, n_hdr, n_ovw, n_miss;
  logic [7:0] mem [int];

  rx_ring_pgmgr #(.PW(PW), .START(8'h46), .STOP(8'h80)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .keep_bad(keep_bad), .rx_vld(rx_vld),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_status(rx_status),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ovw_evt(ovw_evt), .frame_missed(frame_missed), .ring_empty(ring_empty),
    .cur_page(cur_page), .bnd_page(bnd_page)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Port log, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        mem[int'(mem_addr)] = mem_wdata;
        n_wr++;
        if (mem_addr[7:0] < 8'd4) n_hdr++;
      end
      if (ovw_evt) n_ovw++;
      if (frame_missed) n_miss++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int rd(input int a);
    return mem.exists(a) ? int'(mem[a]) : 'h1EE;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; reg_we = 0; reg_sel = 0; reg_wdata = 0; keep_bad = 0;
    rx_vld = 0; rx_eof = 0; rx_data = 0; rx_status = 0;
    repeat (3) @(negedge clk);
    mem.delete();
    n_wr = 0; n_hdr = 0; n_ovw = 0; n_miss = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(input int sel, input int val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = 8'(val);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send_frame(input int n, input int st, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_data = 8'(seed + i);
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_eof = 1'b1; rx_status = 8'(st);
    @(negedge clk);
    rx_eof = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_hdr(input string req, input int pg, input int st,
                         input int nxt, input int cnt);
    chk({req, " hdr status"}, rd(pg*256 + 0), st);
    chk({req, " hdr next"},   rd(pg*256 + 1), nxt);
    chk({req, " hdr cnt lo"}, rd(pg*256 + 2), cnt & 'hFF);
    chk({req, " hdr cnt hi"}, rd(pg*256 + 3), (cnt >> 8) & 'hFF);
  endtask

  task automatic small_ring(input int bnd, input int cur);
    wr_reg(0, 'h10); wr_reg(1, 'h14); wr_reg(2, bnd); wr_reg(3, cur);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cur", cur_page, 'h47);
    chk("R1 bnd", bnd_page, 'h46);
    chk("R1 empty", ring_empty, 1);
    chk("R1 no write", mem_we, 0);
  endtask

  task automatic t_regs();
    do_reset();
    small_ring('h12, 'h13);
    chk("R2 cur", cur_page, 'h13);
    chk("R2 bnd", bnd_page, 'h12);
    chk("R2 empty", ring_empty, 1);
    wr_reg(2, 'h13);
    chk("R2 not empty", ring_empty, 0);
    wr_reg(3, 'h10);
    chk("R2 empty across wrap", ring_empty, 1);
  endtask

  task automatic t_basic();
    int k;
    do_reset();
    @(negedge clk);
    rx_vld = 1'b1; rx_data = 8'h30;
    @(negedge clk);
    rx_data = 8'h31;
    chk("R3 first byte we", mem_we, 1);
    chk("R3 first byte addr", mem_addr, 'h4704);
    chk("R3 first byte data", mem_wdata, 'h30);
    for (int i = 2; i < 10; i++) begin
      @(negedge clk);
      rx_data = 8'(8'h30 + i);
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_eof = 1'b1; rx_status = 8'h21;
    for (k = 0; k < 4; k++) begin
      @(negedge clk);
      rx_eof = 1'b0;
      chk("R5 hdr cycle we", mem_we, 1);
      chk("R5 hdr cycle addr", mem_addr, 'h4700 + k);
      chk("R6 cur timing", cur_page, (k < 3) ? 'h47 : 'h48);
    end
    repeat (3) @(negedge clk);
    chk_hdr("R5", 'h47, 'h21, 'h48, 14);
    chk("R3 last byte", rd('h470D), 'h39);
  endtask

  task automatic t_pageend();
    do_reset();
    send_frame(252, 'h01, 0);
    chk_hdr("R6 page end", 'h47, 'h01, 'h48, 256);
    chk("R6 cur page end", cur_page, 'h48);
    send_frame(1, 'h01, 'hA0);
    chk("R3 next frame data", rd('h4804), 'hA0);
  endtask

  task automatic t_wrap();
    do_reset();
    small_ring('h12, 'h13);
    send_frame(300, 'h01, 0);
    chk("R4 last in top page", rd('h13FF), 251);
    chk("R4 first after wrap", rd('h1000), 252 & 'hFF);
    chk("R4 last byte", rd('h102F), 299 & 'hFF);
    chk_hdr("R4", 'h13, 'h01, 'h11, 304);
    chk("R4 cur", cur_page, 'h11);
  endtask

  task automatic t_bad();
    do_reset();
    send_frame(20, 'h02, 5);
    chk("R7 no header", n_hdr, 0);
    chk("R7 cur kept", cur_page, 'h47);
    keep_bad = 1'b1;
    send_frame(20, 'h02, 5);
    chk_hdr("R7 kept", 'h47, 'h02, 'h48, 24);
    chk("R7 cur moved", cur_page, 'h48);
  endtask

  task automatic t_empty();
    do_reset();
    send_frame(0, 'h01, 0);
    chk_hdr("R10", 'h47, 'h01, 'h48, 4);
    chk("R10 cur", cur_page, 'h48);
    chk("R10 writes", n_wr, 4);
  endtask

  task automatic t_ovf();
    do_reset();
    small_ring('h10, 'h11);
    send_frame(800, 'h01, 0);
    chk("R8 warn", n_ovw, 1);
    chk("R8 missed", n_miss, 1);
    chk("R8 writes stop", n_wr, 764);
    chk("R8 cur kept", cur_page, 'h11);
    send_frame(10, 'h01, 0);
    chk("R9 missed again", n_miss, 2);
    chk("R9 no writes", n_wr, 764);
    chk("R9 single warn", n_ovw, 1);
    wr_reg(2, 'h13);
    send_frame(10, 'h01, 'h55);
    chk("R9 resumed cur", cur_page, 'h12);
    chk("R9 resumed data", rd('h1104), 'h55);
    chk("R9 no extra miss", n_miss, 2);
    send_frame(10, 'h01, 0);
    chk("R8 eof warn", n_ovw, 2);
    chk("R8 eof missed", n_miss, 3);
    chk("R8 eof cur kept", cur_page, 'h12);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0;
    t_reset();
    t_regs();
    t_basic();
    t_pageend();
    t_wrap();
    t_bad();
    t_empty();
    t_ovf();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1 (run completion)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule